// File: doc/BRIEF.md
# Dual-Bank Verified Boot Sequencer

This block is the hardware sequencer that brings a secure microcontroller out of power-on reset. It keeps the processor core in reset until both the logic self-test and the memory self-test report completion. If either of them reports a failure, the core stays in reset for good. If both pass, the core is released to run from ROM at the highest privilege level. The sequencer then walks two verification stages: the bootloader first, then the application firmware. Each stage has a copy in flash bank A and a copy in flash bank B.

For each stage the sequencer asks the flash side for the version words of both copies and tries the newer copy first, with ties going to bank A. It asks an external signature checker to verify that copy through a request/response handshake. A negative answer, or no answer within a programmable number of cycles, makes it retry with the other bank. If both copies of a stage fail, the system is frozen: the core goes back into reset and the block waits for the next power-on reset.

Each stage that passes records the bank that was accepted, locks the settings of the stage that handed over, and lowers the privilege level by one step. The application is released only after its own image has been verified.

Top module: `dual_bank_boot_seq`

## Requirements
- R1: While `rstN` is low and directly after it, `coreRstN` is 0, `privLevel` is 3, `lockVec` is 0, and `frozen`, `appRelease`, `selfTestFail`, `verReq` and `sigReq` are all 0.
- R2: The sequencer waits until both `lbistDone` and `mbistDone` are high. If either `lbistOk` or `mbistOk` is then low, `selfTestFail` goes high and stays high. In that case `coreRstN` stays 0 and no version or signature request is ever made. While only one self-test is done, nothing changes.
- R3: When both self-tests pass, `coreRstN` rises with `privLevel` = 3. In the same cycle `verReq` is high with `verStage` = 0, which selects the bootloader stage (1 selects the application).
- R4: The first signature request of a stage selects bank B (`sigBank` = 1) only when the unsigned `verBankB` is greater than `verBankA`. Otherwise, including when the two are equal, it selects bank A (`sigBank` = 0).
- R5: A failed first attempt is followed at once by a single request for the other bank of the same stage.
- R6: An attempt fails when `timeoutCycles` is T > 0 and `sigDone` has not arrived in the first T cycles of the request. A `sigDone` in the T-th cycle is still accepted. T = 0 disables the timeout.
- R7: When both banks of a stage fail, `frozen` goes high, `coreRstN` goes low and `appRelease` stays 0. This state is left only through `rstN`.
- R8: When a bootloader attempt passes, `blBank` takes the accepted bank, `privLevel` becomes 2 and `lockVec[0]` is set. The application stage then starts with `verStage` = 1.
- R9: When an application attempt passes, `appBank` takes the accepted bank, `privLevel` becomes 1, `lockVec[1]` is set and `appRelease` goes high. Nothing else sets `appRelease`.
- R10: A signature request stays high, with `sigBank` and `sigStage` unchanged, until `sigDone` or the timeout ends it. Each attempt produces exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| lbistDone | input | 1 | Logic self-test finished (level) |
| lbistOk | input | 1 | Logic self-test result, valid with done |
| mbistDone | input | 1 | Memory self-test finished (level) |
| mbistOk | input | 1 | Memory self-test result, valid with done |
| verReq | output | 1 | Version words wanted for the stage on `verStage` |
| verStage | output | 1 | Stage for version read: 0 bootloader, 1 application |
| verValid | input | 1 | One-cycle pulse: version words are valid |
| verBankA | input | VER_W | Version word of the bank A copy |
| verBankB | input | VER_W | Version word of the bank B copy |
| sigReq | output | 1 | Signature verification request |
| sigStage | output | 1 | Stage of the image to verify |
| sigBank | output | 1 | Bank of the image to verify: 0 A, 1 B |
| sigDone | input | 1 | One-cycle pulse ending a request |
| sigOk | input | 1 | Signature verdict, valid with `sigDone` |
| timeoutCycles | input | TO_W | Response window in cycles, 0 disables |
| coreRstN | output | 1 | Core reset, active low |
| selfTestFail | output | 1 | A self-test failed, core held in reset |
| frozen | output | 1 | Both copies of a stage failed |
| appRelease | output | 1 | Verified application released |
| privLevel | output | 2 | 3 ROM, 2 bootloader, 1 application |
| blBank | output | 1 | Accepted bootloader bank |
| appBank | output | 1 | Accepted application bank |
| lockVec | output | 2 | bit0 ROM settings locked, bit1 bootloader settings locked |

## Verification
The hardest situations to reach are the timeout boundaries. A response that lands exactly in the last allowed cycle must be accepted, and a missing one must fail in the same cycle an answer would have been accepted. Each of these has to occur in a second attempt, or in the application stage after a first-stage fallback. The bench drives a signature-checker model whose per-stage, per-bank verdict and response delay are drawn from a fixed seed. The timeout window is drawn from a small range so that delays straddle it. Directed cases pin the delay to T-1 and T, and force ties between version words.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int NUM_STAGES = 2;

  typedef enum logic [2:0] {
    ST_BIST   = 3'd0,
    ST_DEAD   = 3'd1,
    ST_VER    = 3'd2,
    ST_SIG1   = 3'd3,
    ST_SIG2   = 3'd4,
    ST_RUN    = 3'd5,
    ST_FROZEN = 3'd6
  } seqState_e;

  localparam logic STAGE_BL  = 1'b0;
  localparam logic STAGE_APP = 1'b1;

  localparam logic [1:0] PRIV_ROM = 2'd3;
  localparam logic [1:0] PRIV_BL  = 2'd2;
  localparam logic [1:0] PRIV_APP = 2'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  loadPick;  // capture newer-bank choice
    logic                  flipBank;  // move to the other bank
    logic                  clrTimer;  // new attempt starts
    logic                  runTimer;  // attempt in progress
    logic [NUM_STAGES-1:0] commit;    // stage passed
  } dpStrobe_t;
endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lbistDone,
  input  logic      lbistOk,
  input  logic      mbistDone,
  input  logic      mbistOk,
  input  logic      verValid,
  input  logic      sigDone,
  input  logic      sigOk,
  input  logic      timedOut,
  output dpStrobe_t strobe,
  output logic      stage,
  output logic      verReq,
  output logic      sigReq,
  output logic      coreRstN,
  output logic      selfTestFail,
  output logic      frozen,
  output logic      appRelease
);
  seqState_e state, stateNext;
  logic      stageNext;
  logic      attemptEnd;
  logic      attemptOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_BIST;
      stage <= STAGE_BL;
    end else begin
      state <= stateNext;
      stage <= stageNext;
    end
  end

  // A done pulse wins over a timeout in the same cycle
  assign attemptEnd = sigDone || timedOut;
  assign attemptOk  = sigDone && sigOk;

  always_comb begin
    stateNext = state;
    stageNext = stage;
    strobe    = '0;
    unique case (state)
      ST_BIST: begin
        if (lbistDone && mbistDone) begin
          stateNext = (lbistOk && mbistOk) ? ST_VER : ST_DEAD;
        end
      end
      ST_VER: begin
        if (verValid) begin
          strobe.loadPick = 1'b1;
          strobe.clrTimer = 1'b1;
          stateNext       = ST_SIG1;
        end
      end
      ST_SIG1, ST_SIG2: begin
        strobe.runTimer = 1'b1;
        if (attemptEnd) begin
          if (attemptOk) begin
            strobe.commit[stage] = 1'b1;
            if (stage == STAGE_BL) begin
              stageNext = STAGE_APP;
              stateNext = ST_VER;
            end else begin
              stateNext = ST_RUN;
            end
          end else if (state == ST_SIG1) begin
            strobe.flipBank = 1'b1;
            strobe.clrTimer = 1'b1;
            stateNext       = ST_SIG2;
          end else begin
            stateNext = ST_FROZEN;
          end
        end
      end
      default: stateNext = state;
    endcase
  end

  assign verReq       = (state == ST_VER);
  assign sigReq       = (state == ST_SIG1) || (state == ST_SIG2);
  assign coreRstN     = !((state == ST_BIST) || (state == ST_DEAD) || (state == ST_FROZEN));
  assign selfTestFail = (state == ST_DEAD);
  assign frozen       = (state == ST_FROZEN);
  assign appRelease   = (state == ST_RUN);
endmodule

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int VER_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VER_W-1:0] verBankA,
  input  logic [VER_W-1:0] verBankB,
  input  logic [TO_W-1:0]  timeoutCycles,
  output logic             curBank,
  output logic             timedOut,
  output logic [NUM_STAGES-1:0] stageBank,
  output logic [NUM_STAGES-1:0] lockVec,
  output logic [1:0]       privLevel
);
  logic [TO_W-1:0] waitCnt;
  logic            pickB;

  assign pickB = (verBankB > verBankA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBank <= 1'b0;
    end else if (strobe.loadPick) begin
      curBank <= pickB;
    end else if (strobe.flipBank) begin
      curBank <= ~curBank;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.clrTimer) begin
      waitCnt <= '0;
    end else if (strobe.runTimer) begin
      waitCnt <= waitCnt + TO_W'(1);
    end
  end

  assign timedOut = (timeoutCycles != '0) && (waitCnt == timeoutCycles - TO_W'(1));

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic bankQ;
    logic lockQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ <= 1'b0;
        lockQ <= 1'b0;
      end else if (strobe.commit[g]) begin
        bankQ <= curBank;
        lockQ <= 1'b1;
      end
    end
    assign stageBank[g] = bankQ;
    assign lockVec[g]   = lockQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      privLevel <= PRIV_ROM;
    end else if (strobe.commit[1]) begin
      privLevel <= PRIV_APP;
    end else if (strobe.commit[0]) begin
      privLevel <= PRIV_BL;
    end
  end
endmodule

// File: rtl/dual_bank_boot_seq.sv
module dual_bank_boot_seq
  import boot_seq_pkg::*;
#(
  parameter int VER_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lbistDone,
  input  logic             lbistOk,
  input  logic             mbistDone,
  input  logic             mbistOk,
  output logic             verReq,
  output logic             verStage,
  input  logic             verValid,
  input  logic [VER_W-1:0] verBankA,
  input  logic [VER_W-1:0] verBankB,
  output logic             sigReq,
  output logic             sigStage,
  output logic             sigBank,
  input  logic             sigDone,
  input  logic             sigOk,
  input  logic [TO_W-1:0]  timeoutCycles,
  output logic             coreRstN,
  output logic             selfTestFail,
  output logic             frozen,
  output logic             appRelease,
  output logic [1:0]       privLevel,
  output logic             blBank,
  output logic             appBank,
  output logic [1:0]       lockVec
);
  dpStrobe_t             strobe;
  logic                  stage;
  logic                  curBank;
  logic                  timedOut;
  logic [NUM_STAGES-1:0] stageBank;

  boot_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .lbistDone    (lbistDone),
    .lbistOk      (lbistOk),
    .mbistDone    (mbistDone),
    .mbistOk      (mbistOk),
    .verValid     (verValid),
    .sigDone      (sigDone),
    .sigOk        (sigOk),
    .timedOut     (timedOut),
    .strobe       (strobe),
    .stage        (stage),
    .verReq       (verReq),
    .sigReq       (sigReq),
    .coreRstN     (coreRstN),
    .selfTestFail (selfTestFail),
    .frozen       (frozen),
    .appRelease   (appRelease)
  );

  boot_seq_dp #(.VER_W(VER_W), .TO_W(TO_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .verBankA      (verBankA),
    .verBankB      (verBankB),
    .timeoutCycles (timeoutCycles),
    .curBank       (curBank),
    .timedOut      (timedOut),
    .stageBank     (stageBank),
    .lockVec       (lockVec),
    .privLevel     (privLevel)
  );

  assign verStage = stage;
  assign sigStage = stage;
  assign sigBank  = curBank;
  assign blBank   = stageBank[0];
  assign appBank  = stageBank[1];
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int VER_W = 16,
  parameter int TO_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             verReq,
  input logic             verStage,
  input logic             verValid,
  input logic [VER_W-1:0] verBankA,
  input logic [VER_W-1:0] verBankB,
  input logic             sigReq,
  input logic             sigStage,
  input logic             sigBank,
  input logic             sigDone,
  input logic [TO_W-1:0]  timeoutCycles,
  input logic             coreRstN,
  input logic             selfTestFail,
  input logic             frozen,
  input logic             appRelease,
  input logic [1:0]       privLevel,
  input logic [1:0]       lockVec
);
  // Independent count of cycles spent in the current attempt
  logic [TO_W-1:0] reqAge;
  logic            windowEnd;

  assign windowEnd = (timeoutCycles != '0) && (reqAge == timeoutCycles - TO_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAge <= '0;
    end else if (sigReq && !sigDone && !windowEnd) begin
      reqAge <= reqAge + TO_W'(1);
    end else begin
      reqAge <= '0;
    end
  end

  a_r10_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (sigReq && !sigDone && !windowEnd) |=> (sigReq && $stable(sigBank) && $stable(sigStage)));

  a_r4_newer_first: assert property (@(posedge clk) disable iff (!rstN)
    (verReq && verValid) |=> (sigReq && sigBank == ($past(verBankB) > $past(verBankA))
                              && sigStage == $past(verStage)));

  a_r3_rom_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRstN) |-> (privLevel == 2'd3 && verReq && verStage == 1'b0));

  a_r2_dead_sticky: assert property (@(posedge clk) disable iff (!rstN)
    selfTestFail |=> (selfTestFail && !coreRstN && !verReq && !sigReq));

  a_r7_frozen_sticky: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> frozen);

  a_r7_frozen_core: assert property (@(posedge clk) disable iff (!rstN)
    frozen |-> (!coreRstN && !appRelease && !sigReq && !verReq));

  a_r9_release_verified: assert property (@(posedge clk) disable iff (!rstN)
    appRelease |-> (privLevel == 2'd1 && lockVec == 2'b11 && coreRstN));

  a_r8_priv_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    privLevel <= $past(privLevel));
endmodule

bind dual_bank_boot_seq boot_seq_chk #(.VER_W(VER_W), .TO_W(TO_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .verReq        (verReq),
  .verStage      (verStage),
  .verValid      (verValid),
  .verBankA      (verBankA),
  .verBankB      (verBankB),
  .sigReq        (sigReq),
  .sigStage      (sigStage),
  .sigBank       (sigBank),
  .sigDone       (sigDone),
  .timeoutCycles (timeoutCycles),
  .coreRstN      (coreRstN),
  .selfTestFail  (selfTestFail),
  .frozen        (frozen),
  .appRelease    (appRelease),
  .privLevel     (privLevel),
  .lockVec       (lockVec)
);

// File: tb/test_dual_bank_boot_seq.sv
module test_dual_bank_boot_seq;
  localparam int VW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic lbistDone = 1'b0, lbistOk = 1'b0, mbistDone = 1'b0, mbistOk = 1'b0;
  logic verReq, verStage, verValid;
  logic [VW-1:0] verBankA, verBankB;
  logic sigReq, sigStage, sigBank, sigDone, sigOk;
  logic [TW-1:0] timeoutCycles = '0;
  logic coreRstN, selfTestFail, frozen, appRelease, blBank, appBank;
  logic [1:0] privLevel, lockVec;

  dual_bank_boot_seq #(.VER_W(VW), .TO_W(TW)) i_dual_bank_boot_seq (.*);

  int checks = 0;
  int fails = 0;

  // Scenario tables, indexed [stage][bank]
  logic [VW-1:0] verTab [2][2];
  bit            okTab  [2][2];
  int            dlyTab [2][2];
  int            tVal = 0;

  int attempts [2];
  int firstBank [2];
  int verCount = 0;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit passes(input int s, input int b);
    return okTab[s][b] && (tVal == 0 || dlyTab[s][b] < tVal);
  endfunction

  // Version-read responder
  int verWait = -1;
  initial begin
    verValid = 1'b0; verBankA = '0; verBankB = '0;
    forever begin
      @(negedge clk);
      if (verValid) begin
        verValid = 1'b0;
        verWait  = -1;
      end else if (rstN && verReq) begin
        if (verWait < 0) begin
          verWait = int'($urandom_range(3, 0));
          verCount++;
        end
        if (verWait == 0) begin
          verValid = 1'b1;
          verBankA = verTab[verStage][0];
          verBankB = verTab[verStage][1];
        end else begin
          verWait--;
        end
      end else begin
        verWait = -1;
      end
    end
  end

  // Signature-checker responder
  int sigCnt = -1;
  int lastKey = -1;
  int curKey;
  initial begin
    sigDone = 1'b0; sigOk = 1'b0;
    forever begin
      @(negedge clk);
      if (sigDone) begin
        sigDone = 1'b0;
        sigCnt  = -1;
      end
      if (!rstN || !sigReq) begin
        sigCnt = -1;
      end else begin
        curKey = {30'd0, sigStage, sigBank};
        if (sigCnt < 0 || curKey != lastKey) begin
          sigCnt  = 0;
          lastKey = curKey;
          attempts[sigStage]++;
          if (attempts[sigStage] == 1) firstBank[sigStage] = int'(sigBank);
        end else begin
          sigCnt++;
        end
        if ((tVal == 0 || dlyTab[sigStage][sigBank] < tVal) &&
            sigCnt == dlyTab[sigStage][sigBank]) begin
          sigDone = 1'b1;
          sigOk   = okTab[sigStage][sigBank];
        end
      end
    end
  end

  task automatic do_reset();
    rstN = 1'b0;
    lbistDone = 1'b0; lbistOk = 1'b0; mbistDone = 1'b0; mbistOk = 1'b0;
    timeoutCycles = TW'(tVal);
    attempts[0] = 0; attempts[1] = 0;
    firstBank[0] = -1; firstBank[1] = -1;
    verCount = 0;
    repeat (3) @(negedge clk);
    chk(coreRstN == 1'b0 && privLevel == 2'd3 && lockVec == 2'b00 && !frozen &&
        !appRelease && !selfTestFail && !verReq && !sigReq, "R1 reset state",
        {privLevel, lockVec, coreRstN}, 8'b1100_0);
    rstN = 1'b1;
    @(negedge clk);
    chk(coreRstN == 1'b0 && privLevel == 2'd3 && !verReq, "R1 after reset",
        int'(coreRstN), 0);
  endtask

  task automatic run_bist(input bit lok, input bit mok);
    repeat (int'($urandom_range(3, 0))) @(negedge clk);
    lbistDone = 1'b1; lbistOk = lok;
    repeat (int'($urandom_range(3, 0))) @(negedge clk);
    mbistDone = 1'b1; mbistOk = mok;
  endtask

  task automatic run_case(input string name);
    int expBank [2];
    int expAtt [2];
    int expFirst [2];
    bit stagePass [2];
    bit expFrozen;
    int cyc;
    bit seenVer;
    do_reset();
    run_bist(1'b1, 1'b1);
    // R3: core leaves reset at ROM level and asks for bootloader versions
    seenVer = 1'b0;
    for (int i = 0; i < 20 && !seenVer; i++) begin
      @(negedge clk);
      if (verReq) begin
        seenVer = 1'b1;
        chk(coreRstN && privLevel == 2'd3 && verStage == 1'b0, {"R3 rom start ", name},
            {privLevel, verStage, coreRstN}, 4'b1101);
      end
    end
    chk(seenVer, {"R3 version request ", name}, int'(seenVer), 1);

    // Expected outcome from the requirements
    expFrozen = 1'b0;
    for (int s = 0; s < 2; s++) begin
      expFirst[s]  = (verTab[s][1] > verTab[s][0]) ? 1 : 0;
      stagePass[s] = 1'b0;
      expAtt[s]    = 0;
      expBank[s]   = 0;
      if (!expFrozen) begin
        if (passes(s, expFirst[s])) begin
          expAtt[s] = 1; expBank[s] = expFirst[s]; stagePass[s] = 1'b1;
        end else if (passes(s, 1 - expFirst[s])) begin
          expAtt[s] = 2; expBank[s] = 1 - expFirst[s]; stagePass[s] = 1'b1;
        end else begin
          expAtt[s] = 2; expFrozen = 1'b1;
        end
      end
    end

    cyc = 0;
    while (!(appRelease || frozen) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 3000, {"R9 sequence ends ", name}, cyc, 0);
    repeat (5) @(negedge clk);

    chk(frozen == expFrozen, {"R7 frozen ", name}, int'(frozen), int'(expFrozen));
    chk(coreRstN == !expFrozen, {"R7 core reset ", name}, int'(coreRstN), int'(!expFrozen));
    chk(appRelease == !expFrozen, {"R9 release ", name}, int'(appRelease), int'(!expFrozen));
    chk(attempts[0] == expAtt[0], {"R5 R10 bootloader attempts ", name}, attempts[0], expAtt[0]);
    chk(attempts[1] == expAtt[1], {"R5 R10 application attempts ", name}, attempts[1], expAtt[1]);
    chk(firstBank[0] == expFirst[0], {"R4 bootloader first bank ", name}, firstBank[0], expFirst[0]);
    if (stagePass[0]) begin
      chk(int'(blBank) == expBank[0], {"R8 bootloader bank ", name}, int'(blBank), expBank[0]);
      chk(lockVec[0] == 1'b1, {"R8 rom lock ", name}, int'(lockVec[0]), 1);
      chk(firstBank[1] == expFirst[1], {"R4 application first bank ", name},
          firstBank[1], expFirst[1]);
    end else begin
      chk(privLevel == 2'd3 && lockVec == 2'b00, {"R7 no promotion ", name},
          int'(privLevel), 3);
    end
    if (stagePass[1]) begin
      chk(int'(appBank) == expBank[1], {"R9 application bank ", name}, int'(appBank), expBank[1]);
      chk(privLevel == 2'd1 && lockVec == 2'b11, {"R9 privilege ", name},
          {privLevel, lockVec}, 4'b0111);
    end else if (stagePass[0]) begin
      chk(privLevel == 2'd2 && lockVec == 2'b01, {"R8 privilege ", name},
          {privLevel, lockVec}, 4'b1001);
    end
    // R7: terminal, nothing more happens
    repeat (20) @(negedge clk);
    chk(frozen == expFrozen && attempts[0] + attempts[1] == expAtt[0] + expAtt[1],
        {"R7 stays put ", name}, attempts[0] + attempts[1], expAtt[0] + expAtt[1]);
  endtask

  task automatic set_all(input bit ok, input int dly);
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 2; b++) begin
        okTab[s][b] = ok; dlyTab[s][b] = dly; verTab[s][b] = '0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    set_all(1'b1, 1);

    // R2: only one self-test done, nothing moves
    tVal = 0;
    do_reset();
    lbistDone = 1'b1; lbistOk = 1'b1;
    repeat (20) @(negedge clk);
    chk(!coreRstN && !selfTestFail && verCount == 0, "R2 waits for both", verCount, 0);
    // R2: memory self-test fails
    mbistDone = 1'b1; mbistOk = 1'b0;
    repeat (30) @(negedge clk);
    chk(selfTestFail && !coreRstN, "R2 memory fail holds reset", int'(coreRstN), 0);
    chk(verCount == 0 && attempts[0] == 0, "R2 no requests", verCount + attempts[0], 0);
    // R2: logic self-test fails
    do_reset();
    run_bist(1'b0, 1'b1);
    repeat (30) @(negedge clk);
    chk(selfTestFail && !coreRstN && verCount == 0, "R2 logic fail holds reset",
        int'(selfTestFail), 1);

    // R4: equal versions prefer bank A
    set_all(1'b1, 2); tVal = 0;
    verTab[0][0] = 16'd7; verTab[0][1] = 16'd7;
    verTab[1][0] = 16'd3; verTab[1][1] = 16'd9;
    run_case("equal then B newer");

    // R6: response in the last allowed cycle is accepted
    set_all(1'b1, 3); tVal = 4;
    verTab[0][0] = 16'd5; verTab[0][1] = 16'd1;
    run_case("R6 edge accepted");

    // R6: response one cycle late times out, fallback to bank B
    set_all(1'b1, 3); tVal = 4;
    dlyTab[0][0] = 4;
    verTab[0][0] = 16'd5; verTab[0][1] = 16'd1;
    run_case("R6 late timeout");

    // R6: T = 0 disables timeout even for long delays
    set_all(1'b1, 12); tVal = 0;
    run_case("R6 disabled");

    // R5: bootloader first bank rejected, second accepted; app B newer
    set_all(1'b1, 0); tVal = 6;
    okTab[0][1] = 1'b0;
    verTab[0][1] = 16'hFFFF; verTab[0][0] = 16'h0001;
    verTab[1][1] = 16'd2; verTab[1][0] = 16'd1;
    run_case("R5 bootloader fallback");

    // R7: both bootloaders fail
    set_all(1'b0, 1); tVal = 5;
    run_case("R7 bootloader freeze");

    // R7: both applications fail after bootloader fallback
    set_all(1'b1, 1); tVal = 5;
    okTab[0][0] = 1'b0; okTab[1][0] = 1'b0; okTab[1][1] = 1'b0;
    run_case("R7 application freeze");

    // Constrained random scenarios
    for (int n = 0; n < 60; n++) begin
      tVal = int'($urandom_range(8, 0));
      for (int s = 0; s < 2; s++) begin
        for (int b = 0; b < 2; b++) begin
          okTab[s][b]  = ($urandom_range(3, 0) != 0);
          dlyTab[s][b] = int'($urandom_range(8, 0));
          verTab[s][b] = VW'($urandom_range(3, 0));
        end
      end
      run_case($sformatf("random %0d", n));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog expired act=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule